// File: doc/BRIEF.md
# OTP Command Controller Front End

This block places a small register file between a CPU register bus and a one-time-programmable row store. The row store is modelled inside the block as a set of 41-bit rows. Each row is a 32-bit data word plus a 9-bit check field. Software loads a row address, write data and a command code. It then raises a start bit and polls a done flag, which it clears by writing one. The block can read rows and can program a row word by word. Programming can only set bits, never clear them.

Programming stays locked until four program-enable commands arrive carrying the keys 0xF, 0x4, 0x8 and 0xD in that order. A wrong key sends the detector back to the start. Each program-word command uses up the unlock. The 9-bit check code is a placeholder fold of the data word: bit 8 is the parity of all 32 data bits, and bits 7:0 are the XOR of the four data bytes. A read compares the stored check field with this fold and flags a mismatch.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset every register reads zero. The ready flag (offset 0x14, bit 3) reads 0 and rises after INIT_CYC cycles, then stays at 1.
- R2: The register offsets are: control 0x00 (start at bit 0, command code at bits 4:1), address 0x04, write-data-low 0x08, write-data-high 0x0C (bits 8:0), access 0x10, status-A 0x14, status-B 0x18, read-data-low 0x1C and read-data-high 0x20. Written fields read back.
- R3: A command launches only when the start bit goes from 0 to 1 while the block is idle, ready, and CPU access (access bit 15) is 1. Otherwise the start is ignored and no done flag is ever raised for it.
- R4: Status-B bit 1 (done) becomes 1 exactly CMD_LAT+1 clock edges after the write edge that sets start. It stays at 1 until a write with bit 1 set to status-B clears it.
- R5: A read (code 0) puts row bits 31:0 into read-data-low and row bits 40:32 into read-data-high bits 8:0. Bits 31:9 of read-data-high are 0.
- R6: On a read, status-B bit 17 is set when the stored check field differs from the fold of the stored data. When check disable (access bit 9) is 1, bit 17 is 0.
- R7: Program-enable commands (code 2) whose write-data-low equals 0xF, 0x4, 0x8 and 0xD in that order set programming-OK (status-A bit 2).
- R8: A program-enable command with any other value restarts the key sequence. The value 0xF counts as the first key of a new attempt.
- R9: With programming-OK set, program-word (code 10) ORs the new word into the addressed row. The new data comes from write-data-low. The check field comes from write-data-high bits 8:0 when check-write (access bit 8) is 0, and from the fold of the data when it is 1.
- R10: Program-word without programming-OK leaves the row unchanged. Programming-OK is 0 after any program-word completes.
- R11: Clearing CPU access discards any unlock progress and clears programming-OK.
- R12: The row address is held in address-register bits 15:6. Only its low log2(ROWS) bits select the row, so addresses beyond ROWS wrap onto lower rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |

## Verification
The bench programs every row of a 16-row configuration with computed data words. Even rows take a self-generated check field and odd rows take a software-supplied one. Reading the rows back with the check enabled and then disabled therefore separates good rows from bad ones and shows that the flag is masked. Key sequences are tried as the correct order, a wrong third key, a repeated first key and a sequence interrupted by losing CPU access. Each tells apart a different restart rule. Programming a row twice with overlapping words, and programming while locked, shows that rows only gain bits. An aliased address shows the wrap of the row index.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 9;
    localparam int CMD_W  = 4;
    localparam int RADDR_W = 10;
    localparam int RADDR_LSB = 6;
    localparam int KEY_LEN = 4;

    // command codes (software-visible)
    localparam logic [CMD_W-1:0] OP_READ  = 4'd0;
    localparam logic [CMD_W-1:0] OP_UNLK  = 4'd2;
    localparam logic [CMD_W-1:0] OP_PROG  = 4'd10;

    // register offsets
    localparam logic [5:0] OFS_CTL  = 6'h00;
    localparam logic [5:0] OFS_ADR  = 6'h04;
    localparam logic [5:0] OFS_WLO  = 6'h08;
    localparam logic [5:0] OFS_WHI  = 6'h0C;
    localparam logic [5:0] OFS_ACC  = 6'h10;
    localparam logic [5:0] OFS_STA  = 6'h14;
    localparam logic [5:0] OFS_STB  = 6'h18;
    localparam logic [5:0] OFS_RLO  = 6'h1C;
    localparam logic [5:0] OFS_RHI  = 6'h20;

    // bit positions
    localparam int B_CPU_EN  = 15;
    localparam int B_CHK_DIS = 9;
    localparam int B_CHK_WR  = 8;
    localparam int B_READY   = 3;
    localparam int B_PROG_OK = 2;
    localparam int B_DONE    = 1;
    localparam int B_CHK_ERR = 17;

    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
    } row_t;

    typedef enum logic [1:0] {
        SQ_INIT = 2'd0,
        SQ_IDLE = 2'd1,
        SQ_BUSY = 2'd2
    } seq_state_e;

    // placeholder check code: parity of the word plus byte-wise XOR
    function automatic logic [CHK_W-1:0] chk_fold(input logic [DATA_W-1:0] d);
        logic [7:0] x;
        x = d[31:24] ^ d[23:16] ^ d[15:8] ^ d[7:0];
        return {^d, x};
    endfunction

    function automatic logic [DATA_W-1:0] unlock_key(input logic [2:0] i);
        case (i)
            3'd0:    return 32'h0000_000F;
            3'd1:    return 32'h0000_0004;
            3'd2:    return 32'h0000_0008;
            3'd3:    return 32'h0000_000D;
            default: return 32'h0000_0000;
        endcase
    endfunction
endpackage

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int INIT_CYC = 8,
    parameter int CMD_LAT  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_lvl,
    input  logic             cpu_en,
    input  logic [CMD_W-1:0] cmd_in,
    output logic             ready,
    output logic             idle,
    output logic             cpl,
    output logic [CMD_W-1:0] cmd_q
);
    localparam int IW = $clog2(INIT_CYC + 1);
    localparam int LW = (CMD_LAT > 1) ? $clog2(CMD_LAT) : 1;

    seq_state_e      state;
    logic [IW-1:0]   init_cnt;
    logic [LW-1:0]   lat_cnt;
    logic            start_d;
    logic            launch;

    assign ready  = (state != SQ_INIT);
    assign idle   = (state == SQ_IDLE);
    assign launch = start_lvl && !start_d && idle && cpu_en;
    assign cpl    = (state == SQ_BUSY) && (lat_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_INIT;
            init_cnt <= '0;
            lat_cnt  <= '0;
            start_d  <= 1'b0;
            cmd_q    <= '0;
        end else begin
            start_d <= start_lvl;
            case (state)
                SQ_INIT: begin
                    if (init_cnt == IW'(INIT_CYC - 1)) state <= SQ_IDLE;
                    else init_cnt <= init_cnt + 1'b1;
                end
                SQ_IDLE: begin
                    if (launch) begin
                        state   <= SQ_BUSY;
                        cmd_q   <= cmd_in;
                        lat_cnt <= LW'(CMD_LAT - 1);
                    end
                end
                SQ_BUSY: begin
                    if (lat_cnt == '0) state <= SQ_IDLE;
                    else lat_cnt <= lat_cnt - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/otp_unlock.sv
module otp_unlock
    import otp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step_en,
    input  logic              consume,
    input  logic [DATA_W-1:0] value,
    output logic              prog_ok
);
    logic [2:0] step;
    logic       match;

    assign match   = (step != 3'(KEY_LEN)) && (value == unlock_key(step));
    assign prog_ok = (step == 3'(KEY_LEN));

    always_ff @(posedge clk) begin
        if (rst || clear || consume) begin
            step <= '0;
        end else if (step_en) begin
            if (match)                         step <= step + 1'b1;
            else if (value == unlock_key(3'd0)) step <= 3'd1;
            else                               step <= '0;
        end
    end
endmodule

// File: rtl/otp_rows.sv
module otp_rows
    import otp_pkg::*;
#(
    parameter int ROWS = 16,
    localparam int AW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  row_t          wr_row,
    output row_t          rd_row
);
    row_t cells [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (wr_en && idx == AW'(g))
                cells[g] <= row_t'(cells[g] | wr_row);
        end
    end

    assign rd_row = cells[idx];
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
    import otp_pkg::*;
#(
    parameter int ROWS     = 16,
    parameter int INIT_CYC = 8,
    parameter int CMD_LAT  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int AW = $clog2(ROWS);

    logic                start_q;
    logic [CMD_W-1:0]    cmd_code_q;
    logic [RADDR_W-1:0]  radr_q;
    logic [DATA_W-1:0]   wlo_q;
    logic [CHK_W-1:0]    whi_q;
    logic                cpu_en, chk_dis, chk_wr;
    logic [DATA_W-1:0]   rlo_q;
    logic [CHK_W-1:0]    rhi_q;
    logic                done_q, chk_err_q;

    logic                wr_hit;
    logic                seq_ready, seq_idle, cpl;
    logic [CMD_W-1:0]    cmd_q;
    logic                prog_ok;
    logic                cpl_read, cpl_unlk, cpl_prog;
    logic                w1c_done;
    row_t                rd_row, new_row;

    assign wr_hit   = bus_sel && bus_wr;
    assign w1c_done = wr_hit && bus_addr == OFS_STB && bus_wdata[B_DONE];
    assign cpl_read = cpl && cmd_q == OP_READ;
    assign cpl_unlk = cpl && cmd_q == OP_UNLK;
    assign cpl_prog = cpl && cmd_q == OP_PROG;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q    <= 1'b0;
            cmd_code_q <= '0;
            radr_q     <= '0;
            wlo_q      <= '0;
            whi_q      <= '0;
            cpu_en     <= 1'b0;
            chk_dis    <= 1'b0;
            chk_wr     <= 1'b0;
        end else if (wr_hit) begin
            case (bus_addr)
                OFS_CTL: begin
                    start_q    <= bus_wdata[0];
                    cmd_code_q <= bus_wdata[CMD_W:1];
                end
                OFS_ADR: radr_q <= bus_wdata[RADDR_LSB +: RADDR_W];
                OFS_WLO: wlo_q  <= bus_wdata;
                OFS_WHI: whi_q  <= bus_wdata[CHK_W-1:0];
                OFS_ACC: begin
                    cpu_en  <= bus_wdata[B_CPU_EN];
                    chk_dis <= bus_wdata[B_CHK_DIS];
                    chk_wr  <= bus_wdata[B_CHK_WR];
                end
                default: ;
            endcase
        end
    end

    // completion results and write-one-to-clear done
    always_ff @(posedge clk) begin
        if (rst) begin
            rlo_q     <= '0;
            rhi_q     <= '0;
            done_q    <= 1'b0;
            chk_err_q <= 1'b0;
        end else begin
            if (cpl)           done_q <= 1'b1;
            else if (w1c_done) done_q <= 1'b0;
            if (cpl_read) begin
                rlo_q     <= rd_row.data;
                rhi_q     <= rd_row.chk;
                chk_err_q <= !chk_dis && (rd_row.chk != chk_fold(rd_row.data));
            end
        end
    end

    always_comb begin
        new_row.data = wlo_q;
        new_row.chk  = chk_wr ? chk_fold(wlo_q) : whi_q;
    end

    otp_seq #(.INIT_CYC(INIT_CYC), .CMD_LAT(CMD_LAT)) u_seq (
        .clk(clk), .rst(rst), .start_lvl(start_q), .cpu_en(cpu_en),
        .cmd_in(cmd_code_q), .ready(seq_ready), .idle(seq_idle),
        .cpl(cpl), .cmd_q(cmd_q)
    );

    otp_unlock u_unlock (
        .clk(clk), .rst(rst), .clear(!cpu_en), .step_en(cpl_unlk),
        .consume(cpl_prog), .value(wlo_q), .prog_ok(prog_ok)
    );

    otp_rows #(.ROWS(ROWS)) u_rows (
        .clk(clk), .rst(rst), .wr_en(cpl_prog && prog_ok),
        .idx(radr_q[AW-1:0]), .wr_row(new_row), .rd_row(rd_row)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTL: bus_rdata = {27'd0, cmd_code_q, start_q};
            OFS_ADR: bus_rdata[RADDR_LSB +: RADDR_W] = radr_q;
            OFS_WLO: bus_rdata = wlo_q;
            OFS_WHI: bus_rdata[CHK_W-1:0] = whi_q;
            OFS_ACC: begin
                bus_rdata[B_CPU_EN]  = cpu_en;
                bus_rdata[B_CHK_DIS] = chk_dis;
                bus_rdata[B_CHK_WR]  = chk_wr;
            end
            OFS_STA: begin
                bus_rdata[B_READY]   = seq_ready;
                bus_rdata[B_PROG_OK] = prog_ok;
            end
            OFS_STB: begin
                bus_rdata[B_DONE]    = done_q;
                bus_rdata[B_CHK_ERR] = chk_err_q;
            end
            OFS_RLO: bus_rdata = rlo_q;
            OFS_RHI: bus_rdata[CHK_W-1:0] = rhi_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_cmd_chk.sv
module otp_cmd_chk
    import otp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cpu_en,
    input logic             seq_ready,
    input logic             seq_idle,
    input logic             cpl,
    input logic [CMD_W-1:0] cmd_q,
    input logic             done_q,
    input logic             w1c_done,
    input logic             prog_ok
);
    p_ready_holds_r1: assert property (@(posedge clk) disable iff (rst)
        seq_ready |=> seq_ready);

    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && (!cpu_en || !seq_ready)) |=> seq_idle);

    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (w1c_done && !cpl) |=> !done_q);

    p_done_src_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(cpl));

    p_unlock_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_ok) |-> $past(cpl && cmd_q == OP_UNLK));

    p_consume_r10: assert property (@(posedge clk) disable iff (rst)
        (cpl && cmd_q == OP_PROG) |=> !prog_ok);

    p_access_drop_r11: assert property (@(posedge clk) disable iff (rst)
        !cpu_en |=> !prog_ok);
endmodule

bind otp_cmd_ctrl otp_cmd_chk u_chk (
    .clk(clk), .rst(rst), .cpu_en(cpu_en), .seq_ready(seq_ready),
    .seq_idle(seq_idle), .cpl(cpl), .cmd_q(cmd_q), .done_q(done_q),
    .w1c_done(w1c_done), .prog_ok(prog_ok)
);

// File: tb/sim_otp_cmd_ctrl.sv
module sim_otp_cmd_ctrl;
    localparam int ROWS = 16;
    localparam int INIT = 8;
    localparam int LAT  = 3;
    localparam logic [5:0] CTL = 6'h00, ADR = 6'h04, WLO = 6'h08, WHI = 6'h0C,
                           ACC = 6'h10, STA = 6'h14, STB = 6'h18, RLO = 6'h1C, RHI = 6'h20;

    logic clk = 0, rst = 1, bus_sel = 0, bus_wr = 0;
    logic [5:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    int total = 0, bad = 0;
    logic [40:0] shadow [ROWS];

    always #10 clk = ~clk;

    otp_cmd_ctrl #(.ROWS(ROWS), .INIT_CYC(INIT), .CMD_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    function automatic logic [8:0] fold(input logic [31:0] d);
        return {^d, d[31:24] ^ d[23:16] ^ d[15:8] ^ d[7:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic cmd(input logic [3:0] code);
        logic [31:0] s;
        wr(CTL, {27'd0, code, 1'b0});
        wr(CTL, {27'd0, code, 1'b1});
        for (int i = 0; i < 20; i++) begin
            rd(STB, s);
            if (s[1]) break;
            @(negedge clk);
        end
        chk("R4 done seen", {31'd0, s[1]}, 32'd1);
        wr(STB, 32'h2);
        wr(CTL, {27'd0, code, 1'b0});
    endtask

    task automatic unlock4(input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] c, input logic [31:0] d);
        wr(WLO, a); cmd(4'd2);
        wr(WLO, b); cmd(4'd2);
        wr(WLO, c); cmd(4'd2);
        wr(WLO, d); cmd(4'd2);
    endtask

    task automatic read_row(input int r, input bit dis, input string tag);
        logic [31:0] v;
        logic [8:0] hi;
        wr(ACC, (32'h1 << 15) | (dis ? 32'h200 : 32'h0));
        wr(ADR, r << 6);
        cmd(4'd0);
        hi = shadow[r % ROWS][40:32];
        rd(RLO, v); chk({tag, " R5 lo"}, v, shadow[r % ROWS][31:0]);
        rd(RHI, v); chk({tag, " R5 hi"}, v, {23'd0, hi});
        rd(STB, v);
        chk({tag, " R6 err"}, {31'd0, v[17]},
            {31'd0, (!dis && hi != fold(shadow[r % ROWS][31:0]))});
    endtask

    initial begin
        logic [31:0] v, d;
        logic [8:0] e;
        for (int r = 0; r < ROWS; r++) shadow[r] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(STA, v); chk("R1 ready low", v, 32'd0);
        rd(STB, v); chk("R1 stb zero", v, 32'd0);
        rd(ACC, v); chk("R1 acc zero", v, 32'd0);
        rd(CTL, v); chk("R1 ctl zero", v, 32'd0);
        repeat (INIT + 2) @(negedge clk);
        rd(STA, v); chk("R1 ready high", v, 32'h8);

        // R2 readback
        wr(WHI, 32'hFFFF_FFFF); rd(WHI, v); chk("R2 whi", v, 32'h1FF);
        wr(ADR, 32'hFFFF_FFFF); rd(ADR, v); chk("R2 adr R12 field", v, 32'h0000_FFC0);
        wr(CTL, 32'h0000_0014); rd(CTL, v); chk("R2 ctl", v, 32'h14);
        wr(CTL, 0);

        // R3 ignored while access off
        wr(ADR, 0);
        wr(CTL, 1);
        repeat (10) @(negedge clk);
        rd(STB, v); chk("R3 no done without access", v, 32'd0);
        wr(ACC, 32'h8000);
        repeat (10) @(negedge clk);
        rd(STB, v); chk("R3 held start not launched", v, 32'd0);
        wr(CTL, 0);

        // R4 exact latency
        wr(CTL, 1);
        for (int i = 0; i < LAT; i++) @(negedge clk);
        rd(STB, v); chk("R4 not yet done", {31'd0, v[1]}, 32'd0);
        @(negedge clk);
        rd(STB, v); chk("R4 done at latency", {31'd0, v[1]}, 32'd1);
        wr(STB, 32'h0); rd(STB, v); chk("R4 write zero keeps", {31'd0, v[1]}, 32'd1);
        wr(STB, 32'h2); rd(STB, v); chk("R4 w1c", {31'd0, v[1]}, 32'd0);
        wr(CTL, 0);

        // R10 locked program has no effect
        wr(ADR, 3 << 6); wr(WLO, 32'hDEAD_BEEF); wr(WHI, 32'h1AA);
        cmd(4'd10);
        read_row(3, 0, "R10 locked");

        // R7, R9 sweep over all rows
        for (int r = 0; r < ROWS; r++) begin
            d = (32'h9E37_79B9 * (r + 1)) ^ (32'h1 << r);
            e = 9'((r * 53 + 7) & 9'h1FF);
            wr(ACC, 32'h8000 | ((r % 2 == 0) ? 32'h100 : 32'h0));
            unlock4(32'hF, 32'h4, 32'h8, 32'hD);
            rd(STA, v); chk("R7 unlocked", v, 32'hC);
            wr(ADR, r << 6); wr(WLO, d); wr(WHI, {23'd0, e});
            cmd(4'd10);
            shadow[r] = shadow[r] | {((r % 2 == 0) ? fold(d) : e), d};
            rd(STA, v); chk("R10 consumed", v, 32'h8);
        end
        for (int r = 0; r < ROWS; r++) read_row(r, 0, "R9 sweep");
        for (int r = 0; r < ROWS; r += 3) read_row(r, 1, "R6 disabled");

        // R9 OR semantics on row 5
        wr(ACC, 32'h8000);
        unlock4(32'hF, 32'h4, 32'h8, 32'hD);
        wr(ADR, 5 << 6); wr(WLO, 32'h0F0F_0000); wr(WHI, 32'h003);
        cmd(4'd10);
        shadow[5] = shadow[5] | {9'h003, 32'h0F0F_0000};
        read_row(5, 0, "R9 or");

        // R8 wrong key restarts
        unlock4(32'hF, 32'h4, 32'h7, 32'hD);
        rd(STA, v); chk("R8 wrong key", v, 32'h8);
        wr(WLO, 32'hF); cmd(4'd2);
        unlock4(32'hF, 32'h4, 32'h8, 32'hD);
        rd(STA, v); chk("R8 repeated first key", v, 32'hC);
        wr(WLO, 32'h4); cmd(4'd2);
        rd(STA, v); chk("R8 extra key drops", v, 32'h8);

        // R11 access drop discards progress
        wr(WLO, 32'hF); cmd(4'd2);
        wr(WLO, 32'h4); cmd(4'd2);
        wr(WLO, 32'h8); cmd(4'd2);
        wr(ACC, 32'h0); wr(ACC, 32'h8000);
        wr(WLO, 32'hD); cmd(4'd2);
        rd(STA, v); chk("R11 progress lost", v, 32'h8);

        // R12 address wrap: row 18 aliases row 2
        read_row(ROWS + 2, 0, "R12 wrap");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule